// File: doc/BRIEF.md
# Accelerator command and status controller

This block is the control front end of a compute accelerator that sits on a register bus. Software writes a command word to start an operation: a program run, a scrub of the data memory or a scrub of the instruction memory. It reads a status word to follow the operation's progress, and it can read the error code left by the last run. The execution engine and the two scrub engines are outside the block. They report back through single-cycle done strobes, and the execution engine also supplies an error code with its done strobe.

The block tracks one operational state: idle, executing, scrubbing data memory, scrubbing instruction memory, or locked. Locked is permanent until reset. The block enters it on a bus write that completed with an integrity error, on an external fatal condition, or on a software error during execution when the control register treats such errors as fatal. Two alert outputs report trouble. The fatal alert is held high for as long as the block is locked. The recoverable alert pulses once when a program run ends with a nonzero error code. An alert-test register fires either alert on demand. Memory read data from the bus is forced to zero whenever the block is not idle.

Register reads and memory read data both return one cycle after the request, from registers.

Top module: `accel_ctrl`

## Requirements
- R1: A read of the status register (word index 2) returns 0 while idle, 1 while executing, 2 while scrubbing data memory and 3 while scrubbing instruction memory. The value sits in the low byte and the upper bits are zero.
- R2: While the block is locked, a status read returns 0xFF, whatever else is happening.
- R3: A write to the command register (word index 0) starts an operation only if the block is idle and the low byte equals CMD_EXEC, CMD_WIPE_D or CMD_WIPE_I. Any other command write leaves the state unchanged.
- R4: An accepted command moves the state at the clock edge that samples the write, so a status read issued in the next cycle already shows busy.
- R5: A bus write flagged with an integrity error, or a fatal condition strobe, locks the block from any state, including idle. Only reset leaves the locked state.
- R6: The fatal alert output is high in every cycle in which the block is locked, starting with the cycle the lock becomes visible.
- R7: When a program run ends (done strobe while executing) with a nonzero error code, the recoverable alert is high for exactly one cycle. A run that ends with a zero code raises nothing, and neither does a completed scrub.
- R8: A write to the alert-test register (word index 4) with bit 0 set gives a one-cycle fatal alert pulse. With bit 1 set it gives a one-cycle recoverable alert pulse.
- R9: Bit 0 of the control register (word index 1, readable) decides software errors. When it is 1, a software error strobe during execution locks the block. When it is 0, the strobe has no effect.
- R10: Memory read data is passed through with one cycle of latency while idle, and reads as zero while the block is in any other state.
- R11: Reset returns the state to idle and clears the lock, the control bit, the error code and both alerts.
- R12: Done strobes and error codes that arrive while idle or locked are ignored. A scrub done strobe is ignored while executing, and an execution done strobe is ignored while scrubbing.
- R13: The error code register (word index 3) takes the error code given with the execution done strobe and keeps it until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after reg_rd_en, zero otherwise |
| bus_integ_err | input | 1 | A bus write completed with an integrity error |
| fatal_err | input | 1 | External fatal condition strobe |
| sw_err | input | 1 | Software error strobe from the execution engine |
| exec_done | input | 1 | Execution engine finished |
| exec_err_bits | input | ERR_W | Error code given with exec_done |
| wipe_done | input | 1 | Scrub engine finished |
| mem_rdata_in | input | DATA_W | Raw memory read data |
| mem_rdata_out | output | DATA_W | Memory read data after blanking |
| alert_fatal_o | output | 1 | Fatal alert request |
| alert_recov_o | output | 1 | Recoverable alert request |

## Verification
The hardest condition to reach is a lock that coincides with other events: a software error in the same cycle as a done strobe, and done or command inputs arriving after the lock. Reaching it takes a run started with the control bit set, followed by the error strobe during execution. The stimulus then keeps driving done strobes, error codes and commands at the locked block. A behavioural model checks every output in every cycle, so any leak of the later strobes into the error code or the recoverable alert is caught. Scrub completion is also pushed together with a nonzero error code, to confirm that no recoverable alert comes from a scrub.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EXEC   = 3'd1,
    ST_WIPE_D = 3'd2,
    ST_WIPE_I = 3'd3,
    ST_LOCKED = 3'd4
  } op_state_e;

  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_CMD        = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL       = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS     = 3'd2;
  localparam logic [IDX_W-1:0] IDX_ERR        = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ALERT_TEST = 3'd4;
  localparam logic [7:0] STATUS_LOCKED = 8'hFF;
endpackage

// File: rtl/accel_ctrl_fsm.sv
module accel_ctrl_fsm
  import accel_ctrl_pkg::*;
#(
  parameter logic [7:0] CMD_EXEC   = 8'hD8,
  parameter logic [7:0] CMD_WIPE_D = 8'hC3,
  parameter logic [7:0] CMD_WIPE_I = 8'h1E
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic      lock_req,
  input  logic      exec_done,
  input  logic      wipe_done,
  output op_state_e state_q,
  output logic      exec_end
);
  op_state_e state_d;

  assign exec_end = (state_q == ST_EXEC) && exec_done && !lock_req;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_LOCKED || lock_req) begin
      state_d = ST_LOCKED;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr) begin
            if (cmd_code == CMD_EXEC)        state_d = ST_EXEC;
            else if (cmd_code == CMD_WIPE_D) state_d = ST_WIPE_D;
            else if (cmd_code == CMD_WIPE_I) state_d = ST_WIPE_I;
          end
        end
        ST_EXEC:              if (exec_done) state_d = ST_IDLE;
        ST_WIPE_D, ST_WIPE_I: if (wipe_done) state_d = ST_IDLE;
        default:              state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  op_state_e         state_q,
  input  logic              exec_end,
  input  logic [ERR_W-1:0]  exec_err,
  output logic              ctrl_fatal_q,
  output logic [ERR_W-1:0]  err_q,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int unsigned PAD_ERR = DATA_W - ERR_W;
  localparam int unsigned PAD_ST  = DATA_W - 8;

  logic [7:0]        status_byte;
  logic [DATA_W-1:0] rd_mux;

  assign status_byte = (state_q == ST_LOCKED) ? STATUS_LOCKED : {6'd0, state_q[1:0]};

  always_comb begin
    rd_mux = '0;
    unique case (idx)
      IDX_CTRL:   rd_mux = {{(DATA_W-1){1'b0}}, ctrl_fatal_q};
      IDX_STATUS: rd_mux = {{PAD_ST{1'b0}}, status_byte};
      IDX_ERR:    rd_mux = {{PAD_ERR{1'b0}}, err_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_fatal_q <= 1'b0;
      err_q        <= '0;
      rdata_q      <= '0;
    end else begin
      if (wr_en && idx == IDX_CTRL) ctrl_fatal_q <= wdata[0];
      if (exec_end)                 err_q        <= exec_err;
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/accel_ctrl_alerts.sv
module accel_ctrl_alerts (
  input  logic clk,
  input  logic rst,
  input  logic lock_now,
  input  logic exec_end,
  input  logic err_nonzero,
  input  logic test_fatal,
  input  logic test_recov,
  output logic fatal_q,
  output logic recov_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fatal_q <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      fatal_q <= lock_now || test_fatal;
      recov_q <= (exec_end && err_nonzero) || test_recov;
    end
  end
endmodule

// File: rtl/accel_ctrl.sv
module accel_ctrl
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ERR_W      = 8,
  parameter logic [7:0]  CMD_EXEC   = 8'hD8,
  parameter logic [7:0]  CMD_WIPE_D = 8'hC3,
  parameter logic [7:0]  CMD_WIPE_I = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_integ_err,
  input  logic              fatal_err,
  input  logic              sw_err,
  input  logic              exec_done,
  input  logic [ERR_W-1:0]  exec_err_bits,
  input  logic              wipe_done,
  input  logic [DATA_W-1:0] mem_rdata_in,
  output logic [DATA_W-1:0] mem_rdata_out,
  output logic              alert_fatal_o,
  output logic              alert_recov_o
);
  op_state_e        state_q;
  logic             exec_end;
  logic             ctrl_fatal_q;
  logic [ERR_W-1:0] err_q;
  logic             lock_req;
  logic             cmd_wr;
  logic             test_wr;
  logic [DATA_W-1:0] mem_q;

  assign cmd_wr   = reg_wr_en && reg_addr == IDX_CMD;
  assign test_wr  = reg_wr_en && reg_addr == IDX_ALERT_TEST;
  assign lock_req = bus_integ_err || fatal_err
                 || (state_q == ST_EXEC && sw_err && ctrl_fatal_q);

  accel_ctrl_fsm #(
    .CMD_EXEC(CMD_EXEC), .CMD_WIPE_D(CMD_WIPE_D), .CMD_WIPE_I(CMD_WIPE_I)
  ) u_fsm (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(reg_wdata[7:0]),
    .lock_req(lock_req), .exec_done(exec_done), .wipe_done(wipe_done),
    .state_q(state_q), .exec_end(exec_end)
  );

  accel_ctrl_regs #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .idx(reg_addr),
    .wdata(reg_wdata), .state_q(state_q), .exec_end(exec_end),
    .exec_err(exec_err_bits), .ctrl_fatal_q(ctrl_fatal_q), .err_q(err_q),
    .rdata_q(reg_rdata)
  );

  accel_ctrl_alerts u_alerts (
    .clk(clk), .rst(rst),
    .lock_now(lock_req || state_q == ST_LOCKED),
    .exec_end(exec_end), .err_nonzero(|exec_err_bits),
    .test_fatal(test_wr && reg_wdata[0]), .test_recov(test_wr && reg_wdata[1]),
    .fatal_q(alert_fatal_o), .recov_q(alert_recov_o)
  );

  always_ff @(posedge clk) begin
    if (rst) mem_q <= '0;
    else     mem_q <= (state_q == ST_IDLE) ? mem_rdata_in : '0;
  end
  assign mem_rdata_out = mem_q;
endmodule

// File: rtl/accel_ctrl_chk.sv
module accel_ctrl_chk
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter logic [7:0]  CMD_EXEC   = 8'hD8,
  parameter logic [7:0]  CMD_WIPE_D = 8'hC3,
  parameter logic [7:0]  CMD_WIPE_I = 8'h1E
) (
  input logic              clk,
  input logic              rst,
  input op_state_e         state_q,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              bus_integ_err,
  input logic              fatal_err,
  input logic              exec_done,
  input logic              wipe_done,
  input logic [DATA_W-1:0] mem_rdata_out,
  input logic              alert_fatal_o,
  input logic              alert_recov_o
);
  logic good_cmd;
  assign good_cmd = reg_wr_en && reg_addr == IDX_CMD &&
    (reg_wdata[7:0] == CMD_EXEC || reg_wdata[7:0] == CMD_WIPE_D || reg_wdata[7:0] == CMD_WIPE_I);

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_LOCKED |=> state_q == ST_LOCKED);

  p_integ_locks_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_integ_err || fatal_err) |=> state_q == ST_LOCKED);

  p_fatal_held_r6: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_LOCKED |-> alert_fatal_o);

  p_no_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !good_cmd) |=> (state_q == ST_IDLE || state_q == ST_LOCKED));

  p_wipe_no_recov_r7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WIPE_D || state_q == ST_WIPE_I) && !(reg_wr_en && reg_addr == IDX_ALERT_TEST))
    |=> !alert_recov_o);

  p_blank_r10: assert property (@(posedge clk) disable iff (rst)
    state_q != ST_IDLE |=> mem_rdata_out == '0);

  p_idle_done_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && (exec_done || wipe_done) && !good_cmd && !bus_integ_err && !fatal_err)
    |=> state_q == ST_IDLE);
endmodule

bind accel_ctrl accel_ctrl_chk #(
  .DATA_W(DATA_W), .CMD_EXEC(CMD_EXEC), .CMD_WIPE_D(CMD_WIPE_D), .CMD_WIPE_I(CMD_WIPE_I)
) chk_i (
  .clk(clk), .rst(rst), .state_q(state_q), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bus_integ_err(bus_integ_err), .fatal_err(fatal_err),
  .exec_done(exec_done), .wipe_done(wipe_done), .mem_rdata_out(mem_rdata_out),
  .alert_fatal_o(alert_fatal_o), .alert_recov_o(alert_recov_o)
);

// File: tb/accel_ctrl_tb_top.sv
module accel_ctrl_tb_top;
  localparam int DW = 32;
  localparam int EW = 8;
  localparam logic [7:0] C_EX = 8'hD8, C_WD = 8'hC3, C_WI = 8'h1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [2:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, mem_rdata_in = 0;
  logic bus_integ_err = 0, fatal_err = 0, sw_err = 0, exec_done = 0, wipe_done = 0;
  logic [EW-1:0] exec_err_bits = 0;
  logic [DW-1:0] reg_rdata, mem_rdata_out;
  logic alert_fatal_o, alert_recov_o;

  always #10 clk = ~clk;

  accel_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_integ_err(bus_integ_err),
    .fatal_err(fatal_err), .sw_err(sw_err), .exec_done(exec_done),
    .exec_err_bits(exec_err_bits), .wipe_done(wipe_done), .mem_rdata_in(mem_rdata_in),
    .mem_rdata_out(mem_rdata_out), .alert_fatal_o(alert_fatal_o), .alert_recov_o(alert_recov_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference: state 0..3 busy codes, 4 = locked
  int m_st = 0, m_ctrl = 0, m_err = 0;
  logic [DW-1:0] m_rd = 0, m_mem = 0;
  bit m_af = 0, m_ar = 0, m_valid = 0;

  function automatic logic [DW-1:0] model_read(input int a);
    case (a)
      1: return m_ctrl;
      2: return (m_st == 4) ? 32'hFF : m_st;
      3: return m_err;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit lk, ex_end, tw;
    if (rst) begin
      m_st = 0; m_ctrl = 0; m_err = 0; m_rd = 0; m_mem = 0; m_af = 0; m_ar = 0; m_valid = 1;
    end else begin
      lk = bus_integ_err || fatal_err || (m_st == 1 && sw_err && m_ctrl == 1);
      ex_end = (m_st == 1) && exec_done && !lk;
      tw = reg_wr_en && reg_addr == 4;
      m_rd  = reg_rd_en ? model_read(reg_addr) : 0;
      m_mem = (m_st == 0) ? mem_rdata_in : 0;
      m_af  = lk || m_st == 4 || (tw && reg_wdata[0]);
      m_ar  = (ex_end && exec_err_bits != 0) || (tw && reg_wdata[1]);
      if (ex_end) m_err = exec_err_bits;
      if (reg_wr_en && reg_addr == 1) m_ctrl = reg_wdata[0];
      if (m_st == 4 || lk) m_st = 4;
      else if (m_st == 0) begin
        if (reg_wr_en && reg_addr == 0) begin
          if (reg_wdata[7:0] == C_EX) m_st = 1;
          else if (reg_wdata[7:0] == C_WD) m_st = 2;
          else if (reg_wdata[7:0] == C_WI) m_st = 3;
        end
      end else if (m_st == 1 && exec_done) m_st = 0;
      else if ((m_st == 2 || m_st == 3) && wipe_done) m_st = 0;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid && !finished) begin
      check("R1 rdata", reg_rdata, m_rd);
      check("R10 mem", mem_rdata_out, m_mem);
      check("R6 fatal", alert_fatal_o, m_af);
      check("R7 recov", alert_recov_o, m_ar);
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_wr_en = 1; reg_addr = a[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0; reg_wdata = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    reg_rd_en = 1; reg_addr = a[2:0];
    @(negedge clk);
    reg_rd_en = 0;
    v = reg_rdata;
  endtask

  task automatic done_exec(input logic [EW-1:0] e);
    exec_done = 1; exec_err_bits = e;
    @(negedge clk);
    exec_done = 0; exec_err_bits = 0;
  endtask

  task automatic done_wipe();
    wipe_done = 1; exec_err_bits = 8'h3C;
    @(negedge clk);
    wipe_done = 0; exec_err_bits = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(2, v); check("R11 status after reset", v, 0);
    rd(3, v); check("R11 err after reset", v, 0);
    rd(1, v); check("R11 ctrl after reset", v, 0);
    check("R11 fatal after reset", alert_fatal_o, 0);

    mem_rdata_in = 32'h1234_5678;
    @(negedge clk);
    check("R10 idle passthrough", mem_rdata_out, 32'h1234_5678);

    wr(0, 32'h55); rd(2, v); check("R3 bad code ignored", v, 0);
    wr(0, C_EX); rd(2, v); check("R4 busy on next read", v, 1);
    check("R10 blanked while busy", mem_rdata_out, 0);
    wr(0, C_WD); rd(2, v); check("R3 cmd while busy ignored", v, 1);
    wipe_done = 1; @(negedge clk); wipe_done = 0;
    rd(2, v); check("R12 wipe done while exec ignored", v, 1);
    done_exec(0);
    check("R7 zero code no recov", alert_recov_o, 0);
    rd(2, v); check("R1 back to idle", v, 0);

    wr(0, C_EX); done_exec(8'h05);
    check("R7 recov pulse", alert_recov_o, 1);
    @(negedge clk);
    check("R7 recov single cycle", alert_recov_o, 0);
    rd(3, v); check("R13 err code kept", v, 5);

    wr(0, C_WD); rd(2, v); check("R1 wipe data code", v, 2);
    done_exec(8'h77); rd(2, v); check("R12 exec done while wiping ignored", v, 2);
    done_wipe(); check("R7 wipe end no recov", alert_recov_o, 0);
    wr(0, C_WI); rd(2, v); check("R1 wipe instr code", v, 3);
    done_wipe(); rd(2, v); check("R1 idle after wipe", v, 0);

    done_exec(8'h09); check("R12 idle done no recov", alert_recov_o, 0);
    rd(3, v); check("R12 err unchanged", v, 5);

    wr(4, 32'h1); check("R8 test fatal", alert_fatal_o, 1);
    @(negedge clk); check("R8 test fatal one cycle", alert_fatal_o, 0);
    wr(4, 32'h2); check("R8 test recov", alert_recov_o, 1);
    wr(4, 32'h3); check("R8 test both fatal", alert_fatal_o, 1);
    check("R8 test both recov", alert_recov_o, 1);

    wr(0, C_EX); sw_err = 1; @(negedge clk); sw_err = 0;
    rd(2, v); check("R9 sw err non-fatal ignored", v, 1);
    done_exec(0);
    wr(1, 32'h1); rd(1, v); check("R9 ctrl readable", v, 1);
    wr(0, C_EX); sw_err = 1; exec_done = 1; exec_err_bits = 8'h44;
    @(negedge clk); sw_err = 0; exec_done = 0; exec_err_bits = 0;
    check("R9 lock beats done recov", alert_recov_o, 0);
    rd(2, v); check("R2 locked status", v, 32'hFF);
    rd(3, v); check("R9 err not captured on lock", v, 0);
    repeat (5) @(negedge clk);
    check("R6 fatal held", alert_fatal_o, 1);
    done_exec(8'h11); wr(0, C_EX); done_wipe();
    rd(2, v); check("R12 locked ignores inputs", v, 32'hFF);
    rd(3, v); check("R12 err untouched while locked", v, 0);
    mem_rdata_in = 32'hAAAA_5555; @(negedge clk);
    check("R10 blanked while locked", mem_rdata_out, 0);

    do_reset();
    @(negedge clk);
    rd(2, v); check("R11 reset unlocks", v, 0);
    check("R11 fatal cleared", alert_fatal_o, 0);
    bus_integ_err = 1; @(negedge clk); bus_integ_err = 0;
    check("R5 integ lock fatal", alert_fatal_o, 1);
    rd(2, v); check("R5 integ lock from idle", v, 32'hFF);

    do_reset();
    @(negedge clk);
    wr(0, C_WI); fatal_err = 1; @(negedge clk); fatal_err = 0;
    rd(2, v); check("R5 fatal strobe locks wipe", v, 32'hFF);
    repeat (3) @(negedge clk);
    rd(2, v); check("R5 lock sticky", v, 32'hFF);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule